// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port synchronous SRAM with a registered read pipeline and a two-bit wrapping burst address generator. Words are 18 bits wide, made of two 9-bit bytes, and the depth is set by a parameter. On each rising clock edge the block samples the address, three chip enables, two address strobes, an advance input, the write controls and the write data. It classifies the cycle as deselect, begin read, begin write, continue read or write, suspend read or write, or no operation.

A cycle can be started by either of two strobes. The processor strobe always begins a read and has priority over the controller strobe. When the processor strobe begins an access, a write follows on the next edge. The controller strobe can write in its own cycle. While both strobes are high, the advance input steps the burst address or holds it. The burst follows a linear or an interleaved order, chosen by a static mode input.

Read data passes through an output register. A separate tri-state enable tells the surrounding pad logic when the block may drive the shared data bus. That enable follows the output enable input, and the block forces it off on write cycles and on deselects.

Top module: `sync_burst_sram`

## Requirements
- R1: An access is selected only when ce1_ni is 0, ce2_i is 1 and ce3_ni is 0 at a strobe edge. A strobe edge with any chip enable inactive is a deselect and writes nothing.
- R2: If adsp_ni and adsc_ni are both low, only the processor strobe acts, and the write controls are ignored. adsp_ni is ignored while ce1_ni is high, so an ongoing burst goes on as if no strobe were present.
- R3: A processor-strobe cycle is always a read. A write to that address happens on the next edge with both strobes high, using the write controls and data sampled at that edge.
- R4: A controller-strobe write (adsp_ni high, chip selected) writes din_i to addr_i in that same cycle, and adv_ni is ignored in that cycle.
- R5: Write mask: gw_ni low writes both bytes. Otherwise bwe_ni low writes byte b (bits 9b+8:9b) when bw_ni[b] is low. Any other combination writes nothing, and unwritten bytes keep their contents.
- R6: A read registered at edge k shows the data on dout_o with dq_oe_o high after edge k+1. dq_oe_o is high only while oe_ni is low, and it follows oe_ni without a clock.
- R7: After the edge that begins a read from the deselected state, dq_oe_o stays low for that cycle, whatever oe_ni is.
- R8: dq_oe_o is low in the cycle after any write edge. After a write, it stays low until a strobe begins a new read.
- R9: A deselect registered at an edge drops dq_oe_o right after that edge, and any pending read is dropped.
- R10: With both strobes high, adv_ni low steps to the next burst address and adv_ni high holds the current one. With lin_mode_i = 1 the low two address bits count up modulo 4 from the start address. With lin_mode_i = 0 they are the start bits XOR the step count. Upper address bits never change during a burst.
- R11: While rst_ni is low and after reset, dq_oe_o is 0 until a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| ce1_ni | input | 1 | Chip enable, active low; also qualifies adsp_ni |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| adsp_ni | input | 1 | Processor address strobe, active low |
| adsc_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte write enable, active low |
| bw_ni | input | NBYTES | Per-byte write select, active low |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| lin_mode_i | input | 1 | Burst order: 1 linear, 0 interleaved (static) |
| din_i | input | NBYTES*BYTE_W | Write data |
| dout_o | output | NBYTES*BYTE_W | Registered read data |
| dq_oe_o | output | 1 | Data bus drive enable |

## Verification
Each result has a fixed due time. A write takes effect at the edge that samples it and is observed by a later read. Read data and dq_oe_o are due one edge after the read is registered. The high-impedance results of R7, R8 and R9 are due right after the edge that decodes the begin, write or deselect. The bench drives inputs on the falling edge and samples on the falling edge after the edge at which a result is due. The only exception is oe_ni, which is sampled one time step after it changes, with no clock in between. Burst sweeps from every start address in both orders check each beat of the wrap against an address computed arithmetically.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [2:0] {
    CYC_NOP,
    CYC_DESEL,
    CYC_BEG_RD,
    CYC_BEG_WR,
    CYC_CONT_RD,
    CYC_SUSP_RD,
    CYC_CONT_WR,
    CYC_SUSP_WR
  } cyc_e;
endpackage

// File: rtl/sbs_burst_gen.sv
module sbs_burst_gen #(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lin_i,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] cur_o,
  output logic [ADDR_W-1:0] nxt_o
);
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q, cnt_inc, ord_cur, ord_nxt;

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    if (lin_i) begin
      ord_cur = base_q[CNT_W-1:0] + cnt_q;
      ord_nxt = base_q[CNT_W-1:0] + cnt_inc;
    end else begin
      ord_cur = base_q[CNT_W-1:0] ^ cnt_q;
      ord_nxt = base_q[CNT_W-1:0] ^ cnt_inc;
    end
  end

  assign cur_o = {base_q[ADDR_W-1:CNT_W], ord_cur};
  assign nxt_o = {base_q[ADDR_W-1:CNT_W], ord_nxt};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      cnt_q  <= '0;
    end else if (step_i) begin
      cnt_q  <= cnt_inc;
    end
  end

  // R10: hold keeps the address
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!load_i && !step_i) ##1 $stable(lin_i)) |-> $stable(cur_o));
  // R10: a step lands on the announced next address
  a_r10_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((step_i && !load_i) ##1 $stable(lin_i)) |-> (cur_o == $past(nxt_o)));
  // R10: upper bits fixed within a burst
  a_r10_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (cur_o[ADDR_W-1:CNT_W] == $past(cur_o[ADDR_W-1:CNT_W])));
endmodule

// File: rtl/sbs_byte_array.sv
module sbs_byte_array #(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2
) (
  input  logic                     clk_i,
  input  logic [NBYTES-1:0]        we_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic [NBYTES*BYTE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]        raddr_i,
  output logic [NBYTES*BYTE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i[b]) mem[waddr_i] <= wdata_i[b*BYTE_W +: BYTE_W];
    end
    assign rdata_o[b*BYTE_W +: BYTE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     ce1_ni,
  input  logic                     ce2_i,
  input  logic                     ce3_ni,
  input  logic                     adsp_ni,
  input  logic                     adsc_ni,
  input  logic                     adv_ni,
  input  logic                     gw_ni,
  input  logic                     bwe_ni,
  input  logic [NBYTES-1:0]        bw_ni,
  input  logic                     oe_ni,
  input  logic                     lin_mode_i,
  input  logic [NBYTES*BYTE_W-1:0] din_i,
  output logic [NBYTES*BYTE_W-1:0] dout_o,
  output logic                     dq_oe_o
);
  localparam int DATA_W = NBYTES * BYTE_W;
  localparam int CNT_W  = 2;

  cyc_e              cyc;
  logic              sel, p_hit, is_rd, is_wr, load, step;
  logic [NBYTES-1:0] wr_mask, we;
  logic [ADDR_W-1:0] cur_addr, nxt_addr, eff_addr;
  logic              active_q, wmode_q, rd_pend_q, rd_vld_q, wr_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [DATA_W-1:0] rdata, dout_q;

  assign sel   = !ce1_ni && ce2_i && !ce3_ni;
  assign p_hit = !adsp_ni && !ce1_ni;

  always_comb begin
    if (!gw_ni)       wr_mask = '1;
    else if (!bwe_ni) wr_mask = ~bw_ni;
    else              wr_mask = '0;
  end

  always_comb begin
    if (p_hit)                 cyc = sel ? CYC_BEG_RD : CYC_DESEL;
    else if (!adsc_ni)         cyc = !sel ? CYC_DESEL : (|wr_mask ? CYC_BEG_WR : CYC_BEG_RD);
    else if (!active_q)        cyc = CYC_NOP;
    else if (|wr_mask)         cyc = adv_ni ? CYC_SUSP_WR : CYC_CONT_WR;
    else if (wmode_q)          cyc = CYC_NOP;
    else                       cyc = adv_ni ? CYC_SUSP_RD : CYC_CONT_RD;
  end

  assign is_rd = (cyc == CYC_BEG_RD) || (cyc == CYC_CONT_RD) || (cyc == CYC_SUSP_RD);
  assign is_wr = (cyc == CYC_BEG_WR) || (cyc == CYC_CONT_WR) || (cyc == CYC_SUSP_WR);
  assign load  = (cyc == CYC_BEG_RD) || (cyc == CYC_BEG_WR);
  assign step  = (cyc == CYC_CONT_RD) || (cyc == CYC_CONT_WR);
  assign we    = is_wr ? wr_mask : '0;

  always_comb begin
    if (load)      eff_addr = addr_i;
    else if (step) eff_addr = nxt_addr;
    else           eff_addr = cur_addr;
  end

  sbs_burst_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lin_i  (lin_mode_i),
    .load_i (load),
    .step_i (step),
    .base_i (addr_i),
    .cur_o  (cur_addr),
    .nxt_o  (nxt_addr)
  );

  sbs_byte_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_array (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (eff_addr),
    .wdata_i (din_i),
    .raddr_i (rd_addr_q),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      wmode_q   <= 1'b0;
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
      rd_vld_q  <= 1'b0;
      wr_q      <= 1'b0;
      dout_q    <= '0;
    end else begin
      if (load)                   active_q <= 1'b1;
      else if (cyc == CYC_DESEL)  active_q <= 1'b0;
      if (is_wr)                  wmode_q <= 1'b1;
      else if (cyc == CYC_BEG_RD || cyc == CYC_DESEL) wmode_q <= 1'b0;
      rd_pend_q <= is_rd;
      if (is_rd) rd_addr_q <= eff_addr;
      // stage 2: output register; a deselect kills the pending beat
      rd_vld_q  <= rd_pend_q && (cyc != CYC_DESEL);
      wr_q      <= is_wr;
      dout_q    <= rdata;
    end
  end

  assign dout_o  = dout_q;
  assign dq_oe_o = rd_vld_q && !oe_ni && !wr_q;

  // R6: drivers only with output enable low
  a_r6_oe_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o);
  // R6: a read followed by a plain cycle drives per oe_ni
  a_r6_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd ##1 (cyc != CYC_DESEL && !is_wr)) |=> (dq_oe_o == !oe_ni));
  // R7: first cycle of a read from deselect is masked
  a_r7_first_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == CYC_BEG_RD && !active_q) |=> !dq_oe_o);
  // R8: write cycles never drive the bus
  a_r8_wr_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_wr |=> !dq_oe_o);
  // R9: deselect releases the bus at once
  a_r9_desel_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == CYC_DESEL) |=> !dq_oe_o);
  // R2: processor strobe with ce1 high cannot end a burst
  a_r2_ce1_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce1_ni && adsc_ni && active_q) |=> active_q);
endmodule

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
  localparam int AW = 6;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] addr;
  logic ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n, lin;
  logic [1:0] bw_n;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic dq_oe;

  logic [DW-1:0] ref_mem [64];
  int checks = 0;
  int errors = 0;

  sync_burst_sram u_sync_burst_sram (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n),
    .adsp_ni(adsp_n), .adsc_ni(adsc_n), .adv_ni(adv_n),
    .gw_ni(gw_n), .bwe_ni(bwe_n), .bw_ni(bw_n), .oe_ni(oe_n),
    .lin_mode_i(lin), .din_i(din), .dout_o(dout), .dq_oe_o(dq_oe)
  );

  task automatic rest();
    adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 2'b11;
    ce1_n = 0; ce2 = 1; ce3_n = 0; oe_n = 0; din = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_z(input string tag);
    checks++;
    if (dq_oe !== 1'b0) begin
      errors++;
      $display("FAIL %s dq_oe=%0b expected 0", tag, dq_oe);
    end
  endtask

  task automatic chk_d(input string tag, input logic [DW-1:0] exp);
    checks++;
    if (dq_oe !== 1'b1 || dout !== exp) begin
      errors++;
      $display("FAIL %s dq_oe=%0b data=%h expected dq_oe=1 data=%h", tag, dq_oe, dout, exp);
    end
  endtask

  task automatic desel();
    rest(); adsc_n = 0; ce1_n = 1; tick();
  endtask

  function automatic logic [1:0] mask_of(input logic g, input logic be, input logic [1:0] bw);
    if (!g) return 2'b11;
    if (!be) return ~bw;
    return 2'b00;
  endfunction

  task automatic ref_write(input logic [AW-1:0] a, input logic [1:0] m, input logic [DW-1:0] d);
    for (int b = 0; b < 2; b++)
      if (m[b]) ref_mem[a][b*9 +: 9] = d[b*9 +: 9];
  endtask

  task automatic adsc_write(input logic [AW-1:0] a, input logic g, input logic be,
                            input logic [1:0] bw, input logic [DW-1:0] d);
    rest(); adsc_n = 0; addr = a; gw_n = g; bwe_n = be; bw_n = bw; din = d;
    tick();
    ref_write(a, mask_of(g, be, bw), d);
  endtask

  task automatic read_check(input logic [AW-1:0] a, input string tag);
    rest(); adsc_n = 0; addr = a; tick();
    rest(); tick();
    chk_d(tag, ref_mem[a]);
    desel();
  endtask

  function automatic logic [AW-1:0] seq_addr(input logic [AW-1:0] base, input int i, input logic lm);
    logic [1:0] k;
    k = 2'(i);
    if (lm) return {base[AW-1:2], 2'(base[1:0] + k)};
    return {base[AW-1:2], base[1:0] ^ k};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rest(); lin = 1; addr = '0;
    repeat (3) tick();
    chk_z("R11 in reset");
    rst_n = 1;
    tick();
    chk_z("R11 after reset");

    // fill with global writes, one per cycle (R4)
    for (int a = 0; a < 64; a++) begin
      adsc_write(AW'(a), 1'b0, 1'b1, 2'b11, DW'((a * 7919 + 291) ^ (a << 11)));
      if (a == 10) chk_z("R8 during write");
    end
    desel();

    // burst sweep: every start, both orders
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 64; a++) begin
        lin = m[0];
        rest();
        if (m == 0) adsp_n = 0; else adsc_n = 0;
        addr = AW'(a);
        tick();
        chk_z("R7 first cycle masked");
        for (int e = 1; e <= 6; e++) begin
          rest();
          adv_n = (e == 4 || e == 6) ? 1'b1 : 1'b0;
          tick();
          case (e)
            1: chk_d("R6 beat0", ref_mem[seq_addr(AW'(a), 0, m[0])]);
            2: chk_d("R10 beat1", ref_mem[seq_addr(AW'(a), 1, m[0])]);
            3: chk_d("R10 beat2", ref_mem[seq_addr(AW'(a), 2, m[0])]);
            4: chk_d("R10 beat3", ref_mem[seq_addr(AW'(a), 3, m[0])]);
            5: chk_d("R10 hold", ref_mem[seq_addr(AW'(a), 3, m[0])]);
            default: chk_d("R10 wrap", ref_mem[seq_addr(AW'(a), 0, m[0])]);
          endcase
        end
        desel();
        chk_z("R9 deselect");
      end
    end
    lin = 1;

    // byte mask combinations (R5)
    adsc_write(6'd1, 1'b1, 1'b0, 2'b10, 18'h2A5A5);
    adsc_write(6'd2, 1'b1, 1'b0, 2'b01, 18'h15A5A);
    adsc_write(6'd3, 1'b1, 1'b0, 2'b00, 18'h3C3C3);
    adsc_write(6'd4, 1'b1, 1'b0, 2'b11, 18'h00FFF);
    adsc_write(6'd5, 1'b1, 1'b1, 2'b00, 18'h12345);
    adsc_write(6'd6, 1'b0, 1'b1, 2'b11, 18'h0BEEF);
    desel();
    read_check(6'd1, "R5 low byte only");
    read_check(6'd2, "R5 high byte only");
    read_check(6'd3, "R5 both bytes");
    read_check(6'd4, "R5 no byte selected");
    read_check(6'd5, "R5 bwe high no write");
    read_check(6'd6, "R5 global write");

    // R2: both strobes low -> read, no write
    rest(); adsp_n = 0; adsc_n = 0; addr = 6'd20; gw_n = 0; din = 18'h3FFFF; tick();
    chk_z("R2 both strobes first cycle");
    rest(); tick();
    chk_d("R3 processor strobe reads", ref_mem[20]);
    desel();
    read_check(6'd20, "R2 write ignored under both strobes");

    // R2: processor strobe with ce1 high keeps burst alive
    rest(); adsc_n = 0; addr = 6'd21; tick();
    rest(); adsp_n = 0; ce1_n = 1; tick();
    chk_d("R2 ce1 high adsp ignored", ref_mem[21]);
    rest(); tick();
    chk_d("R2 burst still live", ref_mem[21]);
    desel();

    // R3: processor-strobe write on second edge, then burst write
    rest(); adsp_n = 0; addr = 6'd30; gw_n = 0; din = 18'h11111; tick();
    rest(); bwe_n = 0; bw_n = 2'b10; din = 18'h2AAAA; tick();
    ref_write(6'd30, 2'b01, 18'h2AAAA);
    chk_z("R8 write cycle hiz");
    rest(); tick();
    chk_z("R8 stays hiz after write");
    rest(); adv_n = 0; gw_n = 0; din = 18'h0CAFE; tick();
    ref_write(6'd31, 2'b11, 18'h0CAFE);
    desel();
    read_check(6'd30, "R3 second-edge byte write");
    read_check(6'd31, "R3 burst write next address");

    // R4: controller write ignores adv, then continues
    rest(); adsc_n = 0; adv_n = 0; gw_n = 0; addr = 6'd40; din = 18'h1D00D; tick();
    ref_write(6'd40, 2'b11, 18'h1D00D);
    rest(); adv_n = 0; gw_n = 0; din = 18'h2F00F; tick();
    ref_write(6'd41, 2'b11, 18'h2F00F);
    desel();
    read_check(6'd40, "R4 single cycle write at addr_i");
    read_check(6'd41, "R4 continue write next");

    // R1: partial chip enables write nothing / deselect
    rest(); adsc_n = 0; ce3_n = 1; gw_n = 0; addr = 6'd50; din = 18'h3FFFF; tick();
    rest(); adsc_n = 0; ce2 = 0; gw_n = 0; addr = 6'd51; din = 18'h3FFFF; tick();
    read_check(6'd50, "R1 ce3 high no write");
    read_check(6'd51, "R1 ce2 low no write");
    rest(); adsc_n = 0; addr = 6'd52; tick();
    rest(); tick();
    chk_d("R1 selected read", ref_mem[52]);
    rest(); adsc_n = 0; ce2 = 0; tick();
    chk_z("R9 ce2 low deselect");

    // R6: asynchronous output enable
    rest(); adsc_n = 0; addr = 6'd53; tick();
    rest(); oe_n = 1; tick();
    chk_z("R6 oe high");
    oe_n = 0; #1;
    chk_d("R6 oe low again", ref_mem[53]);
    desel();

    // R8: write mid-read, then new strobe read restores bus
    rest(); adsc_n = 0; addr = 6'd54; tick();
    rest(); tick();
    chk_d("R8 read before write", ref_mem[54]);
    rest(); gw_n = 0; din = 18'h13579; tick();
    ref_write(6'd54, 2'b11, 18'h13579);
    chk_z("R8 write over pending read");
    rest(); tick();
    chk_z("R8 no read without strobe");
    rest(); adsp_n = 0; addr = 6'd54; tick();
    rest(); tick();
    chk_d("R8 strobe read after write", ref_mem[54]);
    desel();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule